// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block brings an asynchronous, multiplexed-address DRAM out of power-up and then keeps it refreshed. After reset it holds the memory quiet for a start-up delay. It then runs a fixed burst of refresh cycles before it reports that the memory is ready. From then on it owes the memory one refresh every fixed interval. At 250 MHz the default interval is 3900 cycles, which covers 4096 refreshes in 64 ms.

Each refresh is a CAS-before-RAS cycle. The block drives the row and column strobes itself and holds the write strobe high. It shares the strobes with an access sequencer through a request/grant pair. A small saturating counter tracks how many refreshes are owed, and the request stays up while anything is owed or a cycle is still running. Every duration is a parameter counted in clock cycles.

Top module: `dref_sched`

## Requirements
- R1: While reset is asserted, ras_n, cas_n and we_n are 1, bus_req and init_done are 0, and owed_cnt is 0.
- R2: For the first STARTUP_CYC clock edges after reset release, bus_req stays 0 and both strobes stay high, even if bus_gnt is 1. At edge STARTUP_CYC, owed_cnt is loaded with INIT_CNT.
- R3: init_done rises on the edge after the cycle engine is idle with nothing owed during the initialization phase. It then stays 1 until reset. By that time exactly INIT_CNT falling edges of ras_n have occurred.
- R4: Once init_done is 1, owed_cnt gains one every REF_INTERVAL cycles. The first gain comes REF_INTERVAL edges after init_done rises. With the grant held, successive ras_n falls are REF_INTERVAL cycles apart.
- R5: owed_cnt never exceeds PEND_MAX. An interval gain while at PEND_MAX is dropped. A gain and a completion on the same edge leave owed_cnt unchanged.
- R6: bus_req is 1 exactly when the start-up delay is over and owed_cnt is nonzero, or when a refresh cycle is in progress. This includes its precharge part.
- R7: A refresh cycle starts only on an edge where the engine is idle, bus_gnt is 1, owed_cnt is nonzero and the start-up delay is over. Once started, it runs to the end regardless of bus_gnt.
- R8: A refresh cycle has four parts:
  - T_WE_GUARD cycles with both strobes high;
  - T_CAS_LEAD cycles with cas_n low and ras_n high;
  - T_RAS_LOW cycles with both low;
  - T_PRECHG cycles with both high, after ras_n and cas_n rise on the same edge.
- R9: we_n is 1 at all times, so no refresh cycle is ever seen as a write.
- R10: owed_cnt drops by one on the edge where ras_n rises, unless an interval gain lands on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_gnt | input | 1 | Strobe ownership granted by the access sequencer |
| bus_req | output | 1 | Request for strobe ownership |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| init_done | output | 1 | Initialization burst complete, normal accesses allowed |
| owed_cnt | output | $clog2(max(PEND_MAX,INIT_CNT)+1) | Refreshes currently owed |

## Verification
The bench holds the grant asserted from reset. A scheduler that leaked through the start-up delay would then raise its request or pulse the strobes early. It counts row-strobe falls up to the rising edge of init_done, which catches a burst that ends one refresh short or late. It withholds the grant for many intervals, so a counter without saturation wraps or overshoots PEND_MAX. It also drops the grant in the middle of a cycle, which shows up a cycle that aborts with a shortened row-strobe pulse. Long random grant patterns line up completions with interval gains. A mismatch there shows in owed_cnt against the reference model.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_INIT = 2'd1,
    PH_RUN  = 2'd2
  } phase_t;

  typedef enum logic [2:0] {
    CY_IDLE   = 3'd0,
    CY_GUARD  = 3'd1,
    CY_LEAD   = 3'd2,
    CY_STROBE = 3'd3,
    CY_PRECH  = 3'd4
  } cyc_t;

endpackage

// File: rtl/dref_timebase.sv
// Start-up delay, initialization phase tracking and periodic interval tick.
module dref_timebase
  import dref_pkg::*;
#(
  parameter int unsigned STARTUP_CYC  = 50000,
  parameter int unsigned REF_INTERVAL = 3900
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cyc_idle,
  input  logic   owed_zero,
  output phase_t phase,
  output logic   init_load,
  output logic   tick
);

  localparam int unsigned WAIT_W = $clog2(STARTUP_CYC + 1);
  localparam int unsigned IVL_W  = $clog2(REF_INTERVAL + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(STARTUP_CYC - 1);
  localparam logic [IVL_W-1:0]  IVL_LAST  = IVL_W'(REF_INTERVAL - 1);

  phase_t            phase_q, phase_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [IVL_W-1:0]  ivl_q, ivl_d;
  logic              wait_en, ivl_en;

  always_comb begin
    phase_d   = phase_q;
    wait_d    = wait_q;
    ivl_d     = ivl_q;
    init_load = 1'b0;
    tick      = 1'b0;
    wait_en   = 1'b0;
    ivl_en    = 1'b0;
    case (phase_q)
      PH_WAIT: begin
        if (wait_q == WAIT_LAST) begin
          phase_d   = PH_INIT;
          init_load = 1'b1;
        end else begin
          wait_en = 1'b1;
          wait_d  = wait_q + 1'b1;
        end
      end
      PH_INIT: begin
        if (cyc_idle && owed_zero) phase_d = PH_RUN;
      end
      PH_RUN: begin
        ivl_en = 1'b1;
        if (ivl_q == IVL_LAST) begin
          tick  = 1'b1;
          ivl_d = '0;
        end else begin
          ivl_d = ivl_q + 1'b1;
        end
      end
      default: phase_d = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      wait_q  <= '0;
      ivl_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (wait_en) wait_q <= wait_d;
      if (ivl_en)  ivl_q  <= ivl_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/dref_owed.sv
// Saturating count of refreshes owed to the memory.
module dref_owed #(
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned INIT_CNT = 8,
  localparam int unsigned CAP    = (PEND_MAX > INIT_CNT) ? PEND_MAX : INIT_CNT,
  localparam int unsigned OWED_W = $clog2(CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              inc,
  input  logic              dec,
  output logic [OWED_W-1:0] owed,
  output logic              owed_zero
);

  localparam logic [OWED_W-1:0] SAT_V  = OWED_W'(PEND_MAX);
  localparam logic [OWED_W-1:0] INIT_V = OWED_W'(INIT_CNT);

  logic [OWED_W-1:0] owed_q, owed_d;
  logic              owed_en;

  always_comb begin
    owed_d  = owed_q;
    owed_en = 1'b0;
    if (load) begin
      owed_en = 1'b1;
      owed_d  = INIT_V;
    end else if (inc && !dec) begin
      if (owed_q < SAT_V) begin
        owed_en = 1'b1;
        owed_d  = owed_q + 1'b1;
      end
    end else if (dec && !inc) begin
      if (owed_q != '0) begin
        owed_en = 1'b1;
        owed_d  = owed_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
    end else if (owed_en) begin
      owed_q <= owed_d;
    end
  end

  assign owed      = owed_q;
  assign owed_zero = (owed_q == '0);

endmodule

// File: rtl/dref_cycle.sv
// One CAS-before-RAS refresh cycle: guard, CAS lead, strobe low, precharge.
module dref_cycle
  import dref_pkg::*;
#(
  parameter int unsigned T_WE_GUARD = 3,
  parameter int unsigned T_CAS_LEAD = 2,
  parameter int unsigned T_RAS_LOW  = 13,
  parameter int unsigned T_PRECHG   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ok,
  output logic ras_n,
  output logic cas_n,
  output logic cyc_idle,
  output logic strobe_done
);

  localparam int unsigned M1    = (T_WE_GUARD > T_CAS_LEAD) ? T_WE_GUARD : T_CAS_LEAD;
  localparam int unsigned M2    = (T_RAS_LOW > T_PRECHG) ? T_RAS_LOW : T_PRECHG;
  localparam int unsigned D_MAX = (M1 > M2) ? M1 : M2;
  localparam int unsigned CNT_W = $clog2(D_MAX + 1);
  localparam logic [CNT_W-1:0] GUARD_M1  = CNT_W'(T_WE_GUARD - 1);
  localparam logic [CNT_W-1:0] LEAD_M1   = CNT_W'(T_CAS_LEAD - 1);
  localparam logic [CNT_W-1:0] STROBE_M1 = CNT_W'(T_RAS_LOW - 1);
  localparam logic [CNT_W-1:0] PRECH_M1  = CNT_W'(T_PRECHG - 1);

  cyc_t             state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ras_q, cas_q;
  logic             ras_d, cas_d;
  logic             last;

  assign last = (cnt_q == '0);

  always_comb begin
    state_d     = state_q;
    cnt_d       = last ? cnt_q : cnt_q - 1'b1;
    strobe_done = 1'b0;
    case (state_q)
      CY_IDLE: begin
        cnt_d = cnt_q;
        if (start_ok) begin
          state_d = CY_GUARD;
          cnt_d   = GUARD_M1;
        end
      end
      CY_GUARD: if (last) begin
        state_d = CY_LEAD;
        cnt_d   = LEAD_M1;
      end
      CY_LEAD: if (last) begin
        state_d = CY_STROBE;
        cnt_d   = STROBE_M1;
      end
      CY_STROBE: if (last) begin
        state_d     = CY_PRECH;
        cnt_d       = PRECH_M1;
        strobe_done = 1'b1;
      end
      CY_PRECH: if (last) begin
        state_d = CY_IDLE;
      end
      default: state_d = CY_IDLE;
    endcase
  end

  // Strobes are registered from the next state so they match state_q.
  always_comb begin
    ras_d = !(state_d == CY_STROBE);
    cas_d = !((state_d == CY_LEAD) || (state_d == CY_STROBE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CY_IDLE;
      cnt_q   <= '0;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ras_q   <= ras_d;
      cas_q   <= cas_d;
    end
  end

  assign ras_n    = ras_q;
  assign cas_n    = cas_q;
  assign cyc_idle = (state_q == CY_IDLE);

endmodule

// File: rtl/dref_sched.sv
// Power-up initialization and periodic CAS-before-RAS refresh scheduler.
module dref_sched
  import dref_pkg::*;
#(
  parameter int unsigned STARTUP_CYC  = 50000,
  parameter int unsigned INIT_CNT     = 8,
  parameter int unsigned REF_INTERVAL = 3900,
  parameter int unsigned PEND_MAX     = 8,
  parameter int unsigned T_WE_GUARD   = 3,
  parameter int unsigned T_CAS_LEAD   = 2,
  parameter int unsigned T_RAS_LOW    = 13,
  parameter int unsigned T_PRECHG     = 8,
  localparam int unsigned CAP    = (PEND_MAX > INIT_CNT) ? PEND_MAX : INIT_CNT,
  localparam int unsigned OWED_W = $clog2(CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_gnt,
  output logic              bus_req,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              init_done,
  output logic [OWED_W-1:0] owed_cnt
);

  phase_t phase;
  logic   init_load, tick;
  logic   cyc_idle, strobe_done, owed_zero;
  logic   live, start_ok;

  dref_timebase #(
    .STARTUP_CYC (STARTUP_CYC),
    .REF_INTERVAL(REF_INTERVAL)
  ) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_idle (cyc_idle),
    .owed_zero(owed_zero),
    .phase    (phase),
    .init_load(init_load),
    .tick     (tick)
  );

  dref_owed #(
    .PEND_MAX(PEND_MAX),
    .INIT_CNT(INIT_CNT)
  ) u_owed (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (init_load),
    .inc      (tick),
    .dec      (strobe_done),
    .owed     (owed_cnt),
    .owed_zero(owed_zero)
  );

  assign live     = (phase != PH_WAIT);
  assign start_ok = live && bus_gnt && !owed_zero;

  dref_cycle #(
    .T_WE_GUARD(T_WE_GUARD),
    .T_CAS_LEAD(T_CAS_LEAD),
    .T_RAS_LOW (T_RAS_LOW),
    .T_PRECHG  (T_PRECHG)
  ) u_cyc (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ok   (start_ok),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .cyc_idle   (cyc_idle),
    .strobe_done(strobe_done)
  );

  assign bus_req   = (live && !owed_zero) || !cyc_idle;
  assign we_n      = 1'b1;
  assign init_done = (phase == PH_RUN);

endmodule

// File: rtl/dref_sched_chk.sv
module dref_sched_chk #(
  parameter int unsigned STARTUP_CYC = 50000,
  parameter int unsigned INIT_CNT    = 8,
  parameter int unsigned PEND_MAX    = 8,
  localparam int unsigned CAP    = (PEND_MAX > INIT_CNT) ? PEND_MAX : INIT_CNT,
  localparam int unsigned OWED_W = $clog2(CAP + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              ras_n,
  input logic              cas_n,
  input logic              init_done,
  input logic [OWED_W-1:0] owed_cnt
);

  localparam int unsigned SU_W = $clog2(STARTUP_CYC + 1);
  localparam logic [SU_W-1:0]   SU_V  = SU_W'(STARTUP_CYC);
  localparam logic [OWED_W-1:0] CAP_V = OWED_W'(CAP);

  logic [SU_W-1:0] su_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          su_q <= '0;
    else if (su_q < SU_V) su_q <= su_q + 1'b1;
  end

  // R2
  startup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (su_q < SU_V) |-> (!bus_req && ras_n && cas_n));

  // R8
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  // R8
  ras_under_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  // R8
  joint_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);

  // R6
  strobe_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> bus_req);

  // R5
  owed_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed_cnt <= CAP_V);

  // R3
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R10
  owed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $past(init_done)) |->
      (({1'b0, owed_cnt}) <= ({1'b0, $past(owed_cnt)} + 1'b1)) &&
      (({1'b0, $past(owed_cnt)}) <= ({1'b0, owed_cnt} + 1'b1)));

endmodule

bind dref_sched dref_sched_chk #(
  .STARTUP_CYC(STARTUP_CYC),
  .INIT_CNT   (INIT_CNT),
  .PEND_MAX   (PEND_MAX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .init_done(init_done),
  .owed_cnt (owed_cnt)
);

// File: tb/dref_sched_test.sv
module dref_sched_test;

  localparam int SU = 40, INIT = 8, IV = 60, PMAX = 8;
  localparam int TW = 3, TC = 2, TR = 13, TP = 8;
  localparam int TOT = TW + TC + TR + TP;
  localparam int OW = $clog2(PMAX + 1);
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n, bus_gnt;
  logic bus_req, ras_n, cas_n, we_n, init_done;
  logic [OW-1:0] owed_cnt;

  always #2 clk = ~clk;

  dref_sched #(
    .STARTUP_CYC(SU), .INIT_CNT(INIT), .REF_INTERVAL(IV), .PEND_MAX(PMAX),
    .T_WE_GUARD(TW), .T_CAS_LEAD(TC), .T_RAS_LOW(TR), .T_PRECHG(TP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .init_done(init_done),
    .owed_cnt(owed_cnt)
  );

  int checks = 0, bad = 0, cyc = 0;
  bit cmp_en = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wrap_up();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  // Behavioural reference: phase, owed count and position inside a refresh.
  int m_phase, m_wait, m_owed, m_ivl, m_pos;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_wait = 0; m_owed = 0; m_ivl = 0; m_pos = -1;
    end else begin
      bit start, dec, tick, idle_old;
      int owed_old, ph_old;
      start    = (m_pos < 0) && bus_gnt && (m_owed > 0) && (m_phase != 0);
      dec      = (m_pos == TW + TC + TR - 1);
      tick     = (m_phase == 2) && (m_ivl == IV - 1);
      idle_old = (m_pos < 0);
      owed_old = m_owed;
      ph_old   = m_phase;
      if (start) m_pos = 0;
      else if (m_pos >= 0) m_pos = (m_pos == TOT - 1) ? -1 : m_pos + 1;
      if (ph_old == 0 && m_wait == SU - 1) m_owed = INIT;
      else if (tick && !dec) begin if (m_owed < PMAX) m_owed++; end
      else if (dec && !tick) m_owed--;
      case (ph_old)
        0: if (m_wait == SU - 1) m_phase = 1; else m_wait++;
        1: if (idle_old && owed_old == 0) m_phase = 2;
        default: m_ivl = (m_ivl == IV - 1) ? 0 : m_ivl + 1;
      endcase
    end
  end

  // Monitor and per-cycle comparison, sampled at the falling edge.
  int falls = 0, rises = 0, lead_run = 0, last_lead = 0, low_run = 0, last_low = 0;
  int fall_q[$];
  logic prev_ras = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ras_n && !cas_n) lead_run++;
      else if (ras_n) lead_run = 0;
      if (!ras_n && prev_ras) begin
        falls++; last_lead = lead_run; lead_run = 0; fall_q.push_back(cyc);
      end
      if (!ras_n) low_run++;
      if (ras_n && !prev_ras) begin rises++; last_low = low_run; low_run = 0; end
      prev_ras = ras_n;
    end
    if (cmp_en) begin
      bit e_ras, e_cas, e_req;
      e_ras = !(m_pos >= TW + TC && m_pos <= TW + TC + TR - 1);
      e_cas = !(m_pos >= TW && m_pos <= TW + TC + TR - 1);
      e_req = ((m_phase != 0) && (m_owed > 0)) || (m_pos >= 0);
      chk("R8 ras_n", int'(ras_n), int'(e_ras));
      chk("R8 cas_n", int'(cas_n), int'(e_cas));
      chk("R6 bus_req", int'(bus_req), int'(e_req));
      chk("R3 init_done", int'(init_done), (m_phase == 2) ? 1 : 0);
      chk("R5 owed_cnt", int'(owed_cnt), m_owed);
      chk("R9 we_n", int'(we_n), 1);
    end
    if (cyc >= LIMIT) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      wrap_up();
    end
  end

  initial begin
    int f0, r0;
    rst_n = 1'b0; bus_gnt = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ras_n", int'(ras_n), 1);
    chk("R1 cas_n", int'(cas_n), 1);
    chk("R1 we_n", int'(we_n), 1);
    chk("R1 bus_req", int'(bus_req), 0);
    chk("R1 init_done", int'(init_done), 0);
    chk("R1 owed_cnt", int'(owed_cnt), 0);
    rst_n = 1'b1; cmp_en = 1;

    // R2 quiet start-up delay although granted
    repeat (SU - 1) @(negedge clk);
    chk("R2 bus_req in delay", int'(bus_req), 0);
    chk("R2 no strobe in delay", falls, 0);
    @(negedge clk);
    chk("R2 bus_req after delay", int'(bus_req), 1);
    chk("R2 owed loaded", int'(owed_cnt), INIT);

    // R10 first completion decrements the owed count
    while (rises < 1) @(negedge clk);
    chk("R10 owed after first rise", int'(owed_cnt), INIT - 1);
    chk("R8 cas lead length", last_lead, TC);
    chk("R8 ras low length", last_low, TR);
    chk("R8 req held in precharge", int'(bus_req), 1);

    // R3 initialization burst count
    while (!init_done) @(negedge clk);
    chk("R3 burst falls", falls, INIT);
    chk("R3 owed empty", int'(owed_cnt), 0);

    // R4 spacing between periodic refreshes
    while (falls < INIT + 2) @(negedge clk);
    chk("R4 interval spacing", fall_q[INIT + 1] - fall_q[INIT], IV);

    // R5 and R7: withhold grant long enough to saturate
    bus_gnt = 1'b0;
    repeat (TOT + 2) @(negedge clk);
    f0 = falls;
    repeat (10 * IV) @(negedge clk);
    chk("R7 no start without grant", falls, f0);
    chk("R5 saturated owed", int'(owed_cnt), PMAX);
    chk("R6 req while owed", int'(bus_req), 1);

    // R7 grant dropped mid-cycle: cycle still completes
    bus_gnt = 1'b1;
    r0 = rises;
    while (falls == f0) @(negedge clk);
    bus_gnt = 1'b0;
    while (rises == r0) @(negedge clk);
    chk("R7 full pulse after grant drop", last_low, TR);
    bus_gnt = 1'b1;
    repeat (10 * TOT) @(negedge clk);

    // Random grant pattern against the reference model
    repeat (3000) begin
      @(negedge clk);
      bus_gnt = ($urandom_range(0, 3) != 0);
    end
    bus_gnt = 1'b1;
    repeat (20 * TOT) @(negedge clk);
    chk("R5 drained", int'(owed_cnt) <= 1 ? 1 : 0, 1);
    wrap_up();
  end

endmodule